// File: doc/BRIEF.md
# Glitch-Guarded Serial Configuration Receiver

This block takes configuration words that arrive bit by bit over three slow lines: a serial clock, the complement of that clock, and a data line. A bit is taken only when a rising edge on the clock and a falling edge on the complement arrive together, within a short window of system clocks. A spurious edge on one line alone, such as a glitch coupled in from interference, is therefore dropped. All three lines are first resynchronised into the system clock domain.

The top holds two independent receivers. The first takes an 8-bit source-gate word, with one enable bit per source. The second takes a 32-bit gain word, which splits into eight 4-bit gain codes, one per amplifier channel. Each receiver builds its word in a hidden shift register. It copies the word to its parallel outputs only when the last bit has arrived, and pulses an update strobe for one cycle when it does. A stuck or shorted clock pair raises an error flag. A stalled transfer is discarded quietly.

Top module: `ser_cfg_top`

## Requirements
- R1: The gate receiver takes 8 bits. Received bit n (n = 1..8) appears on gate_word_o[n-1], so the first bit received lands in the LSB.
- R2: The gain receiver takes 32 bits. Received bit n appears on gain_code_o[n-1]. Channel c (c = 1..8) reads its code from gain_code_o[4c-1:4c-4], and the earliest bit of each field is that field's LSB.
- R3: A bit is accepted when a clock rise and a complement fall happen in the same cycle, or when the second of the two edges follows the first by at most 2 system clocks. A lone clock pulse, a lone complement dip, and an edge pair 3 or more cycles apart each add no bit.
- R4: The parallel outputs change only when the final bit of a word is accepted. The update strobe goes high for exactly one cycle at the same edge. That edge is the third rising edge of clk_i after the completing line edge is presented, and the outputs and the strobe do not change before it.
- R5: If the synchronised clock and complement sit at the same level for more than 4 consecutive system clocks, the receiver discards the partial word, restarts at bit 1 and sets its error flag. A run of exactly 4 equal cycles has no effect. The flag stays set until the next update strobe, which clears it.
- R6: If more than 1024 system clocks pass without an accepted bit while a word is partly received, the partial word is dropped and the next bit counts as bit 1. The error flag is not set. A gap of 1024 cycles or fewer keeps the partial word.
- R7: After reset, both parallel words, both strobes and both error flags are zero.
- R8: Activity on one receiver's lines leaves the other receiver's outputs, strobe and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gate_sclk_i | input | 1 | Gate receiver serial clock |
| gate_sclk_n_i | input | 1 | Gate receiver complementary clock |
| gate_sdat_i | input | 1 | Gate receiver serial data |
| gain_sclk_i | input | 1 | Gain receiver serial clock |
| gain_sclk_n_i | input | 1 | Gain receiver complementary clock |
| gain_sdat_i | input | 1 | Gain receiver serial data |
| gate_word_o | output | 8 | Source enables, bit 0 = source 1 |
| gate_upd_o | output | 1 | One-cycle strobe when gate_word_o is reloaded |
| gate_err_o | output | 1 | Gate clock-pair fault flag |
| gain_code_o | output | 32 | Eight 4-bit gain codes, channel 1 in bits 3:0 |
| gain_upd_o | output | 1 | One-cycle strobe when gain_code_o is reloaded |
| gain_err_o | output | 1 | Gain clock-pair fault flag |

## Verification
Each line change passes through two synchroniser flops and one output register. A completed word and its strobe therefore appear at the third rising clk_i edge after the edge that completes it. The bench samples on falling edges, where it sees the old word and a low strobe after the second rising edge, and the new word and a high strobe after the third. The error flag and the idle timeout are checked many cycles after their cause, so sync delay cannot hide a result. Gap lengths of 900 and 1100 cycles sit well clear of the 1024-cycle limit. The equal-level run is held for exactly 4 and then 8 cycles.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;
  localparam int unsigned PAIR_WIN_D = 2;
  localparam int unsigned LVL_MAX_D  = 4;
  localparam int unsigned IDLE_MAX_D = 1024;
  localparam int unsigned SYNC_W     = 3;
  // sync bit order {dat, clk_n, clk}; clk_n idles high
  localparam logic [SYNC_W-1:0] SYNC_RST = 3'b010;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/ser_pair_qual.sv
module ser_pair_qual #(
  parameter int unsigned PAIR_WIN = ser_cfg_pkg::PAIR_WIN_D,
  parameter int unsigned LVL_MAX  = ser_cfg_pkg::LVL_MAX_D
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sclk_n_i,
  input  logic sdat_i,
  output logic bit_vld_o,
  output logic bit_dat_o,
  output logic fault_o
);
  localparam int unsigned WIN_W = $clog2(PAIR_WIN + 1);
  localparam int unsigned EQ_W  = $clog2(LVL_MAX + 2);
  localparam logic [WIN_W-1:0] WIN_LD  = WIN_W'(PAIR_WIN);
  localparam logic [EQ_W-1:0]  EQ_TRIG = EQ_W'(LVL_MAX);
  localparam logic [EQ_W-1:0]  EQ_SAT  = EQ_W'(LVL_MAX + 1);

  logic clk_q, clk_n_q, dat_hold;
  logic [WIN_W-1:0] rise_win, fall_win;
  logic [EQ_W-1:0]  eq_cnt;
  logic rise, fall, eq;
  logic pair_now, pair_fall_late, pair_rise_late;

  assign rise = sclk_i & ~clk_q;
  assign fall = ~sclk_n_i & clk_n_q;
  assign eq   = (sclk_i == sclk_n_i);

  assign fault_o        = eq && (eq_cnt == EQ_TRIG);
  assign pair_now       = rise & fall;
  assign pair_fall_late = fall & ~rise & (rise_win != '0);
  assign pair_rise_late = rise & ~fall & (fall_win != '0);
  assign bit_vld_o      = ~fault_o & (pair_now | pair_fall_late | pair_rise_late);
  // data belongs to the clock rise; hold it when the rise came first
  assign bit_dat_o      = pair_fall_late ? dat_hold : sdat_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q    <= 1'b0;
      clk_n_q  <= 1'b1;
      dat_hold <= 1'b0;
      rise_win <= '0;
      fall_win <= '0;
      eq_cnt   <= '0;
    end else begin
      clk_q   <= sclk_i;
      clk_n_q <= sclk_n_i;
      if (rise) dat_hold <= sdat_i;

      if (!eq)                 eq_cnt <= '0;
      else if (eq_cnt != EQ_SAT) eq_cnt <= eq_cnt + 1'b1;

      if (fault_o || bit_vld_o) begin
        rise_win <= '0;
        fall_win <= '0;
      end else begin
        if (rise)                rise_win <= WIN_LD;
        else if (rise_win != '0) rise_win <= rise_win - 1'b1;
        if (fall)                fall_win <= WIN_LD;
        else if (fall_win != '0) fall_win <= fall_win - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
  parameter int unsigned WORD_W   = 8,
  parameter int unsigned IDLE_MAX = ser_cfg_pkg::IDLE_MAX_D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_vld_i,
  input  logic              bit_dat_i,
  input  logic              fault_i,
  output logic [WORD_W-1:0] word_o,
  output logic              upd_o,
  output logic              err_o
);
  localparam int unsigned CNT_W  = $clog2(WORD_W);
  localparam int unsigned IDLE_W = $clog2(IDLE_MAX + 1);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [IDLE_W-1:0] IDLE_LIM = IDLE_W'(IDLE_MAX);

  logic [WORD_W-2:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic [IDLE_W-1:0] idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh     <= '0;
      cnt    <= '0;
      idle   <= '0;
      word_o <= '0;
      upd_o  <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      upd_o <= 1'b0;
      if (fault_i) begin
        cnt   <= '0;
        idle  <= '0;
        err_o <= 1'b1;
      end else if (bit_vld_i) begin
        idle <= '0;
        if (cnt == LAST_BIT) begin
          word_o <= {bit_dat_i, sh};
          upd_o  <= 1'b1;
          err_o  <= 1'b0;
          cnt    <= '0;
        end else begin
          sh  <= {bit_dat_i, sh[WORD_W-2:1]};
          cnt <= cnt + 1'b1;
        end
      end else if (cnt != '0) begin
        if (idle == IDLE_LIM) begin
          cnt  <= '0;
          idle <= '0;
        end else begin
          idle <= idle + 1'b1;
        end
      end else begin
        idle <= '0;
      end
    end
  end
endmodule

// File: rtl/ser_rx.sv
module ser_rx #(
  parameter int unsigned WORD_W   = 8,
  parameter int unsigned PAIR_WIN = ser_cfg_pkg::PAIR_WIN_D,
  parameter int unsigned LVL_MAX  = ser_cfg_pkg::LVL_MAX_D,
  parameter int unsigned IDLE_MAX = ser_cfg_pkg::IDLE_MAX_D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sclk_n_i,
  input  logic              sdat_i,
  output logic [WORD_W-1:0] word_o,
  output logic              upd_o,
  output logic              err_o
);
  import ser_cfg_pkg::*;

  logic [SYNC_W-1:0] sync_q;
  logic bit_vld, bit_dat, fault;

  ser_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sdat_i, sclk_n_i, sclk_i}),
    .q_o    (sync_q)
  );

  ser_pair_qual #(.PAIR_WIN(PAIR_WIN), .LVL_MAX(LVL_MAX)) u_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_i    (sync_q[0]),
    .sclk_n_i  (sync_q[1]),
    .sdat_i    (sync_q[2]),
    .bit_vld_o (bit_vld),
    .bit_dat_o (bit_dat),
    .fault_o   (fault)
  );

  ser_shift #(.WORD_W(WORD_W), .IDLE_MAX(IDLE_MAX)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_vld_i (bit_vld),
    .bit_dat_i (bit_dat),
    .fault_i   (fault),
    .word_o    (word_o),
    .upd_o     (upd_o),
    .err_o     (err_o)
  );
endmodule

// File: rtl/ser_cfg_top.sv
module ser_cfg_top #(
  parameter int unsigned GATE_W  = 8,
  parameter int unsigned GAIN_CH = 8,
  parameter int unsigned CODE_W  = 4,
  parameter int unsigned GAIN_W  = GAIN_CH * CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gate_sclk_i,
  input  logic              gate_sclk_n_i,
  input  logic              gate_sdat_i,
  input  logic              gain_sclk_i,
  input  logic              gain_sclk_n_i,
  input  logic              gain_sdat_i,
  output logic [GATE_W-1:0] gate_word_o,
  output logic              gate_upd_o,
  output logic              gate_err_o,
  output logic [GAIN_W-1:0] gain_code_o,
  output logic              gain_upd_o,
  output logic              gain_err_o
);
  ser_rx #(.WORD_W(GATE_W)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_i   (gate_sclk_i),
    .sclk_n_i (gate_sclk_n_i),
    .sdat_i   (gate_sdat_i),
    .word_o   (gate_word_o),
    .upd_o    (gate_upd_o),
    .err_o    (gate_err_o)
  );

  ser_rx #(.WORD_W(GAIN_W)) u_gain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_i   (gain_sclk_i),
    .sclk_n_i (gain_sclk_n_i),
    .sdat_i   (gain_sdat_i),
    .word_o   (gain_code_o),
    .upd_o    (gain_upd_o),
    .err_o    (gain_err_o)
  );
endmodule

// File: rtl/ser_rx_chk.sv
module ser_rx_chk #(
  parameter int unsigned WORD_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bit_vld_i,
  input logic              fault_i,
  input logic [WORD_W-1:0] word_i,
  input logic              upd_i,
  input logic              err_i
);
  p_upd_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> !upd_i);

  p_word_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |-> $stable(word_i));

  p_upd_from_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> $past(bit_vld_i));

  p_err_on_fault_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> err_i);

  p_err_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_i) |-> upd_i);
endmodule

bind ser_rx ser_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_vld_i (bit_vld),
  .fault_i   (fault),
  .word_i    (word_o),
  .upd_i     (upd_o),
  .err_i     (err_o)
);

// File: tb/ser_cfg_top_tb_top.sv
module ser_cfg_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gt_clk = 1'b0, gt_clkn = 1'b1, gt_dat = 1'b0;
  logic gn_clk = 1'b0, gn_clkn = 1'b1, gn_dat = 1'b0;
  logic [7:0]  gate_word;
  logic [31:0] gain_code;
  logic gate_upd, gate_err, gain_upd, gain_err;
  int n_chk = 0, n_err = 0;
  int gt_upd_n = 0, gn_upd_n = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ser_cfg_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .gate_sclk_i(gt_clk), .gate_sclk_n_i(gt_clkn), .gate_sdat_i(gt_dat),
    .gain_sclk_i(gn_clk), .gain_sclk_n_i(gn_clkn), .gain_sdat_i(gn_dat),
    .gate_word_o(gate_word), .gate_upd_o(gate_upd), .gate_err_o(gate_err),
    .gain_code_o(gain_code), .gain_upd_o(gain_upd), .gain_err_o(gain_err)
  );

  always @(negedge clk) begin
    if (gate_upd) gt_upd_n++;
    if (gain_upd) gn_upd_n++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // sel 0 = gate lines, 1 = gain lines
  task automatic drv(input bit sel, input logic c, input logic cn, input logic d, input int n);
    if (!sel) begin gt_clk = c; gt_clkn = cn; gt_dat = d; end
    else      begin gn_clk = c; gn_clkn = cn; gn_dat = d; end
    repeat (n) @(negedge clk);
  endtask

  // mode 0 together, 1 complement leads by 1, 2 clock leads by 2
  task automatic send_bit(input bit sel, input logic d, input int mode);
    drv(sel, 1'b0, 1'b1, d, 4);
    if (mode == 1) drv(sel, 1'b0, 1'b0, d, 1);
    if (mode == 2) drv(sel, 1'b1, 1'b1, d, 2);
    drv(sel, 1'b1, 1'b0, d, 4);
  endtask

  task automatic send_bits(input bit sel, input logic [31:0] w, input int first, input int last);
    for (int i = first; i <= last; i++) send_bit(sel, w[i], 0);
  endtask

  function automatic logic [31:0] out_word(input bit sel);
    return sel ? gain_code : {24'h0, gate_word};
  endfunction

  function automatic logic out_upd(input bit sel);
    return sel ? gain_upd : gate_upd;
  endfunction

  // full word with the R4 latency checked on the last bit
  task automatic send_word_lat(input bit sel, input logic [31:0] w, input int n, input string req);
    logic [31:0] old;
    send_bits(sel, w, 0, n - 2);
    drv(sel, 1'b0, 1'b1, w[n-1], 4);
    old = out_word(sel);
    drv(sel, 1'b1, 1'b0, w[n-1], 2);
    check("R4 strobe early", {31'h0, out_upd(sel)}, 32'h0);
    check("R4 word early", out_word(sel), old);
    drv(sel, 1'b1, 1'b0, w[n-1], 1);
    check("R4 strobe due", {31'h0, out_upd(sel)}, 32'h1);
    check(req, out_word(sel), w);
    drv(sel, 1'b1, 1'b0, w[n-1], 1);
    check("R4 strobe single", {31'h0, out_upd(sel)}, 32'h0);
  endtask

  initial begin
    logic [31:0] w;
    int u0, u1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 gate word", {24'h0, gate_word}, 32'h0);
    check("R7 gain code", gain_code, 32'h0);
    check("R7 strobes flags", {28'h0, gate_upd, gate_err, gain_upd, gain_err}, 32'h0);

    // R1 exhaustive gate sweep
    for (int v = 0; v < 256; v++) begin
      u0 = gt_upd_n;
      send_word_lat(1'b0, 32'(v), 8, "R1 gate word");
      check("R4 one strobe per word", 32'(gt_upd_n - u0), 32'h1);
    end
    check("R8 gain untouched by gate", gain_code, 32'h0);
    check("R8 gain strobe count", 32'(gn_upd_n), 32'h0);

    // R2 per-channel code sweep
    for (int k = 0; k < 16; k++) begin
      w = '0;
      for (int c = 0; c < 8; c++) w[4*c +: 4] = 4'((k + 3 * c) % 16);
      send_word_lat(1'b1, w, 32, "R2 gain word");
      for (int c = 0; c < 8; c++)
        check("R2 channel field", {28'h0, gain_code[4*c +: 4]}, 32'((k + 3 * c) % 16));
    end
    check("R8 gate untouched by gain", {24'h0, gate_word}, 32'h0000_00ff);

    // R3 skewed pairs accepted, glitches rejected
    w = 32'h0000_00b6;
    u0 = gt_upd_n;
    for (int i = 0; i < 8; i++) begin
      send_bit(1'b0, w[i], i % 3);
      drv(1'b0, 1'b0, 1'b1, 1'b1, 2);
      drv(1'b0, 1'b1, 1'b1, 1'b1, 2);   // lone clock pulse
      drv(1'b0, 1'b0, 1'b1, 1'b1, 2);
      drv(1'b0, 1'b0, 1'b0, 1'b1, 2);   // lone complement dip
      drv(1'b0, 1'b0, 1'b1, 1'b1, 2);
      drv(1'b0, 1'b0, 1'b0, 1'b1, 3);   // pair 3 cycles apart
      drv(1'b0, 1'b1, 1'b0, 1'b1, 3);
    end
    drv(1'b0, 1'b0, 1'b1, 1'b0, 6);
    check("R3 skewed word", {24'h0, gate_word}, w);
    check("R3 no extra bits", 32'(gt_upd_n - u0), 32'h1);

    // R5 four equal cycles tolerated
    w = 32'h0000_003c;
    send_bits(1'b0, w, 0, 1);
    drv(1'b0, 1'b0, 1'b0, 1'b0, 4);
    send_bits(1'b0, w, 2, 7);
    drv(1'b0, 1'b0, 1'b1, 1'b0, 6);
    check("R5 four equal ok word", {24'h0, gate_word}, w);
    check("R5 four equal no flag", {31'h0, gate_err}, 32'h0);

    // R5 long equal run: flag, restart
    u0 = gt_upd_n;
    send_bits(1'b0, 32'h0000_00ff, 0, 2);
    drv(1'b0, 1'b1, 1'b1, 1'b1, 8);
    drv(1'b0, 1'b0, 1'b1, 1'b0, 8);
    check("R5 flag set", {31'h0, gate_err}, 32'h1);
    check("R5 word kept", {24'h0, gate_word}, w);
    check("R5 no strobe", 32'(gt_upd_n - u0), 32'h0);
    check("R8 gain flag clear", {31'h0, gain_err}, 32'h0);
    send_word_lat(1'b0, 32'h0000_00a5, 8, "R5 restart word");
    check("R5 flag cleared", {31'h0, gate_err}, 32'h0);

    // R6 idle gaps on the gain receiver
    w = 32'h1357_9bdf;
    u1 = gn_upd_n;
    send_bits(1'b1, 32'hffff_ffff, 0, 9);
    drv(1'b1, 1'b0, 1'b1, 1'b0, 1100);
    send_bits(1'b1, w, 0, 31);
    drv(1'b1, 1'b0, 1'b1, 1'b0, 6);
    check("R6 long gap discards", gain_code, w);
    check("R6 single strobe", 32'(gn_upd_n - u1), 32'h1);
    check("R6 no flag", {31'h0, gain_err}, 32'h0);
    w = 32'h8421_c3a5;
    send_bits(1'b1, w, 0, 9);
    drv(1'b1, 1'b0, 1'b1, 1'b0, 900);
    send_bits(1'b1, w, 10, 31);
    drv(1'b1, 1'b0, 1'b1, 1'b0, 6);
    check("R6 short gap keeps", gain_code, w);
    check("R8 gate unchanged", {24'h0, gate_word}, 32'h0000_00a5);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule